// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

The block collects a parameterised number of external request lines and keeps three state bits for each: enable, pending and active. Each line also holds a priority field. A single command port sets and clears enables and pending bits, writes priorities, sets the grouping split and raises a request by line number in software. The enable, pending and active bits are visible as plain read-back vectors. Any one line's priority can be read back through a separate read port.

In every cycle the controller picks the most urgent request that is both enabled and pending. It then compares that request's preempt part against the running level, which is the most urgent preempt part among the active lines. When the new request is strictly more urgent, the block offers a vector number to the core. The core answers with an acknowledge, which moves the line from pending to active. When a handler finishes, the core reports the line back, and the controller retires it and re-pends it if its input is still high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all enables, pending and active bits are 0, every priority reads 0 (the most urgent level), the grouping value is 0 and `irq_valid` is low.
- R2: A priority write (`cmd_op`=4) stores only `cmd_data[7:4]`. The read port returns `{stored,4'b0000}` for the line on `rd_line`, and returns 0 when `rd_line` names no line.
- R3: Command op 0 sets and op 1 clears the enable bit of `cmd_line`. Op 2 sets and op 3 clears its pending bit. Commands naming a line number at or beyond the line count change nothing. Active bits change only through acknowledge and return.
- R4: A request input sets its pending bit on any rising edge, and also while it is held high and the line is not active. A level held high on an active line does not re-pend it.
- R5: Among lines that are enabled and pending, the selected line has the numerically smallest full 4-bit priority. Ties go to the lowest line number.
- R6: Op 5 sets the grouping value G to `cmd_data`, saturated to 4. The low G bits of each 4-bit priority are subpriority and the upper 4-G bits are the preempt part. With G=4 nothing preempts an active line.
- R7: `irq_valid` is high exactly when a line is selected and its preempt part is strictly smaller than the smallest preempt part among active lines. When no line is active, a selected line is always offered.
- R8: While `irq_valid` is high, `irq_vector` equals the selected line number plus 16. It is derived in the same cycle from the registered state.
- R9: When `irq_valid` and `irq_ack` are both high, the selected line's pending bit clears and its active bit sets at the next edge.
- R10: When `ret_valid` is high, the active bit of `ret_line` clears at the next edge. If that line's input is high in the same cycle, its pending bit sets.
- R11: Op 6 (software trigger) sets the pending bit of `cmd_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Request inputs, held levels or single-cycle pulses |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0..6) |
| cmd_line | input | LW | Line addressed by the command |
| cmd_data | input | 8 | Priority byte or grouping value |
| rd_line | input | LW | Line whose priority is read back |
| rd_prio | output | 8 | Priority of `rd_line`, low nibble zero |
| enable_o | output | NUM_LINES | Enable bits |
| pending_o | output | NUM_LINES | Pending bits |
| active_o | output | NUM_LINES | Active bits |
| irq_valid | output | 1 | A request may be taken now |
| irq_vector | output | VW | Vector number of the offered request |
| irq_ack | input | 1 | Core takes the offered request |
| ret_valid | input | 1 | Handler of `ret_line` has finished |
| ret_line | input | LW | Line being retired |

## Verification
The bench builds the controller with NUM_LINES=20 and PRIO_BITS=4. The 5-bit line index then reaches the numbers 20 to 31, which name no line, so ignored commands and reads are exercised. With only twenty lines, random pulses and held levels often collide on the same line while it is active, pending and being retired. The grouping values cover every split from full preemption to none, including values above 4 that saturate.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_LINES = 82,
  parameter int PRIO_BITS = 4,  // must be below 8
  localparam int LW = $clog2(NUM_LINES),
  localparam int VW = $clog2(NUM_LINES + 16),
  localparam int GW = $clog2(PRIO_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [LW-1:0]        cmd_line,
  input  logic [7:0]           cmd_data,
  input  logic [LW-1:0]        rd_line,
  output logic [7:0]           rd_prio,
  output logic [NUM_LINES-1:0] enable_o,
  output logic [NUM_LINES-1:0] pending_o,
  output logic [NUM_LINES-1:0] active_o,
  output logic                 irq_valid,
  output logic [VW-1:0]        irq_vector,
  input  logic                 irq_ack,
  input  logic                 ret_valid,
  input  logic [LW-1:0]        ret_line
);
  localparam logic [2:0] OP_SETEN = 3'd0, OP_CLREN = 3'd1, OP_SETPD = 3'd2,
                         OP_CLRPD = 3'd3, OP_PRIO = 3'd4, OP_GROUP = 3'd5, OP_TRIG = 3'd6;

  logic [NUM_LINES-1:0] en_q, pd_q, ac_q, irq_q, en_d, pd_d, ac_d;
  logic [PRIO_BITS-1:0] prio_q [NUM_LINES];
  logic [PRIO_BITS-1:0] prio_d [NUM_LINES];
  logic [GW-1:0]        grp_q;
  logic [PRIO_BITS-1:0] pmask, best_pr;
  logic [PRIO_BITS:0]   run_pr;
  logic [LW-1:0]        best_line;
  logic                 found, take;

  assign enable_o  = en_q;
  assign pending_o = pd_q;
  assign active_o  = ac_q;
  assign rd_prio   = (int'(rd_line) < NUM_LINES) ?
                     {prio_q[rd_line], {(8-PRIO_BITS){1'b0}}} : 8'd0;

  always_comb
    for (int b = 0; b < PRIO_BITS; b++) pmask[b] = (b >= int'(grp_q));

  always_comb begin
    found     = 1'b0;
    best_pr   = '0;
    best_line = '0;
    run_pr    = {1'b1, {PRIO_BITS{1'b0}}};
    for (int i = 0; i < NUM_LINES; i++) begin
      if (en_q[i] && pd_q[i] && (!found || prio_q[i] < best_pr)) begin
        found     = 1'b1;
        best_pr   = prio_q[i];
        best_line = LW'(i);
      end
      if (ac_q[i] && {1'b0, prio_q[i] & pmask} < run_pr)
        run_pr = {1'b0, prio_q[i] & pmask};
    end
  end

  assign irq_valid  = found && ({1'b0, best_pr & pmask} < run_pr);
  assign irq_vector = VW'(best_line) + VW'(16);
  assign take       = irq_valid && irq_ack;

  always_comb
    for (int i = 0; i < NUM_LINES; i++) begin
      logic hit, tk, rt;
      hit = cmd_valid && (cmd_line == LW'(i));
      tk  = take && (best_line == LW'(i));
      rt  = ret_valid && (ret_line == LW'(i));
      en_d[i] = (en_q[i] | (hit && cmd_op == OP_SETEN)) & ~(hit && cmd_op == OP_CLREN);
      pd_d[i] = (pd_q[i] & ~((hit && cmd_op == OP_CLRPD) | tk))
              | (irq_in[i] & ~ac_q[i] & ~tk)
              | (irq_in[i] & ~irq_q[i])
              | (hit && (cmd_op == OP_SETPD || cmd_op == OP_TRIG))
              | (rt & irq_in[i]);
      ac_d[i] = (ac_q[i] & ~rt) | tk;
      prio_d[i] = (hit && cmd_op == OP_PRIO) ? cmd_data[7 -: PRIO_BITS] : prio_q[i];
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      en_q  <= '0;
      pd_q  <= '0;
      ac_q  <= '0;
      irq_q <= '0;
      grp_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= '0;
    end else begin
      en_q  <= en_d;
      pd_q  <= pd_d;
      ac_q  <= ac_d;
      irq_q <= irq_in;
      prio_q <= prio_d;
      if (cmd_valid && cmd_op == OP_GROUP)
        grp_q <= (cmd_data > 8'(PRIO_BITS)) ? GW'(PRIO_BITS) : cmd_data[GW-1:0];
    end

  p_vector_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector >= VW'(16)) && (int'(irq_vector) < NUM_LINES + 16));

  p_offer_is_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> enable_o[irq_vector - VW'(16)] && pending_o[irq_vector - VW'(16)]);

  p_take_sets_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> active_o[$past(best_line)]);

  p_return_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && int'(ret_line) < NUM_LINES && !(take && best_line == ret_line))
      |=> !active_o[$past(ret_line)]);

  p_no_preempt_all_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(grp_q) == PRIO_BITS && |active_o) |-> !irq_valid);
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int N = 20;
  localparam int LW = $clog2(N);
  localparam int VW = $clog2(N + 16);

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic cmd_valid = 0, irq_ack = 0, ret_valid = 0;
  logic [2:0] cmd_op = '0;
  logic [LW-1:0] cmd_line = '0, rd_line = '0, ret_line = '0;
  logic [7:0] cmd_data = '0, rd_prio;
  logic [N-1:0] enable_o, pending_o, active_o;
  logic irq_valid;
  logic [VW-1:0] irq_vector;

  prio_irq_ctrl #(.NUM_LINES(N), .PRIO_BITS(4)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .cmd_data(cmd_data), .rd_line(rd_line), .rd_prio(rd_prio),
    .enable_o(enable_o), .pending_o(pending_o), .active_o(active_o),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ack(irq_ack),
    .ret_valid(ret_valid), .ret_line(ret_line));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit m_en[N], m_pd[N], m_ac[N], m_iq[N];
  int m_pr[N];
  int m_grp = 0;

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void expect_offer(output bit v, output int line);
    int mask, run, bp;
    bit found = 0;
    mask = (m_grp >= 4) ? 0 : ((15 >> m_grp) << m_grp);
    run = 16; bp = 0; line = 0;
    for (int i = 0; i < N; i++) begin
      if (m_en[i] && m_pd[i] && (!found || m_pr[i] < bp)) begin
        found = 1; bp = m_pr[i]; line = i;
      end
      if (m_ac[i] && (m_pr[i] & mask) < run) run = m_pr[i] & mask;
    end
    v = found && ((bp & mask) < run);
  endfunction

  task automatic compare();
    bit ev; int el;
    logic [N-1:0] ve, vp, va;
    int erd;
    expect_offer(ev, el);
    for (int i = 0; i < N; i++) begin ve[i] = m_en[i]; vp[i] = m_pd[i]; va[i] = m_ac[i]; end
    erd = (int'(rd_line) < N) ? (m_pr[rd_line] << 4) : 0;
    check(irq_valid === ev, "R7 valid", int'(irq_valid), int'(ev));
    if (ev) check(int'(irq_vector) == el + 16, "R5 R8 vector", int'(irq_vector), el + 16);
    check(enable_o === ve, "R3 enable", int'(enable_o), int'(ve));
    check(pending_o === vp, "R4 pending", int'(pending_o), int'(vp));
    check(active_o === va, "R9 R10 active", int'(active_o), int'(va));
    check(int'(rd_prio) == erd, "R2 prio read", int'(rd_prio), erd);
  endtask

  task automatic model_step();
    bit ev; int el, tk, rl;
    expect_offer(ev, el);
    tk = (ev && irq_ack) ? el : -1;
    rl = ret_valid ? int'(ret_line) : -1;
    for (int i = 0; i < N; i++) begin
      bit hit;
      hit = cmd_valid && int'(cmd_line) == i;
      if (hit && cmd_op == 0) m_en[i] = 1;
      if (hit && cmd_op == 1) m_en[i] = 0;
      if ((hit && cmd_op == 3) || tk == i) m_pd[i] = 0;
      if ((irq_in[i] && !m_ac[i] && tk != i) || (irq_in[i] && !m_iq[i]) ||
          (hit && (cmd_op == 2 || cmd_op == 6)) || (rl == i && irq_in[i])) m_pd[i] = 1;
      if (rl == i) m_ac[i] = 0;
      if (tk == i) m_ac[i] = 1;
      if (hit && cmd_op == 4) m_pr[i] = cmd_data >> 4;
      m_iq[i] = irq_in[i];
    end
    if (cmd_valid && cmd_op == 5) m_grp = (cmd_data > 4) ? 4 : int'(cmd_data);
  endtask

  task automatic tick();
    #1 compare();
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(int op, int line, int data);
    cmd_valid = 1; cmd_op = 3'(op); cmd_line = LW'(line); cmd_data = 8'(data);
    tick();
    cmd_valid = 0;
  endtask

  task automatic ack();
    irq_ack = 1; tick(); irq_ack = 0;
  endtask

  task automatic retire(int line);
    ret_valid = 1; ret_line = LW'(line); tick(); ret_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_pd[i] = 0; m_ac[i] = 0; m_iq[i] = 0; m_pr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(irq_valid == 0 && enable_o == 0 && active_o == 0, "R1 reset state", int'(irq_valid), 0);
    check(rd_prio == 0, "R1 reset priority", int'(rd_prio), 0);
    tick();

    rd_line = 3;
    cmd(4, 3, 8'hA7);
    check(rd_prio == 8'hA0, "R2 low nibble dropped", int'(rd_prio), 8'hA0);
    cmd(0, 2, 0); cmd(0, 3, 0); cmd(0, 5, 0); cmd(0, 25, 0);
    check(enable_o == 20'h0002C, "R3 enable set, out-of-range ignored", int'(enable_o), 'h2C);
    cmd(2, 5, 0);
    check(irq_valid && irq_vector == 21, "R8 vector is line plus 16", int'(irq_vector), 21);
    cmd(1, 5, 0);
    check(!irq_valid && pending_o[5], "R3 disabled line not offered", int'(irq_valid), 0);
    cmd(0, 5, 0);
    ack();
    check(active_o[5] && !pending_o[5], "R9 ack moves pending to active", int'(active_o[5]), 1);

    irq_in[3] = 1; tick(); irq_in[3] = 0; tick();
    check(pending_o[3] == 1, "R4 pulse latched", int'(pending_o[3]), 1);
    check(irq_valid == 0, "R7 less urgent does not preempt", int'(irq_valid), 0);
    retire(5);
    check(!active_o[5] && !pending_o[5], "R10 return clears active", int'(active_o[5]), 0);
    check(irq_valid && irq_vector == 19, "R7 offered once idle", int'(irq_vector), 19);
    ack();

    irq_in[2] = 1; tick();
    check(irq_valid && irq_vector == 18, "R7 more urgent preempts", int'(irq_vector), 18);
    ack(); tick();
    check(pending_o[2] == 0, "R4 held level on active line not re-pended", int'(pending_o[2]), 0);
    retire(2);
    check(pending_o[2] == 1, "R10 still-high input re-pends", int'(pending_o[2]), 1);
    irq_in[2] = 0;
    ack(); retire(2); retire(3);

    cmd(4, 2, 8'h50); cmd(4, 5, 8'h5F);
    cmd(2, 5, 0); cmd(2, 2, 0);
    check(irq_valid && irq_vector == 18, "R5 tie goes to lowest line", int'(irq_vector), 18);
    ack();
    cmd(4, 3, 8'h40);
    cmd(6, 3, 0);
    check(pending_o[3] == 1, "R11 software trigger pends", int'(pending_o[3]), 1);
    check(irq_valid && irq_vector == 19, "R6 grouping 0 preempts on low bit", int'(irq_vector), 19);
    cmd(5, 0, 1);
    check(irq_valid == 0, "R6 grouping 1 shares preempt level", int'(irq_valid), 0);
    cmd(5, 0, 9);
    check(irq_valid == 0, "R6 saturated grouping blocks preemption", int'(irq_valid), 0);
    cmd(5, 0, 0);
    retire(2);

    for (int c = 0; c < 3000; c++) begin
      int na, pick;
      irq_in = N'($urandom & $urandom & $urandom);
      cmd_valid = ($urandom_range(0, 2) == 0);
      cmd_op = 3'($urandom_range(0, 7));
      cmd_line = LW'($urandom_range(0, 23));
      cmd_data = 8'($urandom);
      rd_line = LW'($urandom_range(0, 23));
      irq_ack = $urandom_range(0, 1);
      na = 0;
      for (int i = 0; i < N; i++) if (m_ac[i]) na++;
      ret_valid = (na > 0) && ($urandom_range(0, 3) == 0);
      if (ret_valid) begin
        pick = $urandom_range(0, na - 1);
        for (int i = 0; i < N; i++)
          if (m_ac[i]) begin
            if (pick == 0) ret_line = LW'(i);
            pick--;
          end
      end
      tick();
    end
    cmd_valid = 0; irq_ack = 0; ret_valid = 0; irq_in = '0;
    tick();
    report();
  end
endmodule